// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with Compare Channel

This block is a general-purpose timer reached over a simple register bus. A programmable divider turns the system clock into count ticks, and an up-counter steps once per tick from zero up to a programmable top value. On the tick after the top value it returns to zero and raises an update event. A single compare channel flags the tick on which the counter steps onto a programmed value. Each of the two flags can drive one level interrupt output on its own.

Software can write an event-generation bit to restart the counter and the divider phase. The same write moves the new divider value and any buffered top value into the active copies. Control bits choose among several behaviours: a wrap that gives no update event, a single run that stops at the first update event, and a top value that is either buffered or applied at once. A parameter sets the counter width to 16 or 32 bits. The top-value register keeps only the bits that exist, so software can find the width by writing all ones and reading the register back.

Top module: `cmp_timer`

## Requirements
- R1: Registers are at byte offsets control 0x00, interrupt enable 0x0C, status 0x10, event generation 0x14, counter 0x24, divider 0x28, top value 0x2C and compare 0x34. Control bit 0 is run, bit 1 suppresses wrap updates, bit 3 is single run and bit 7 buffers the top value. After reset, control, interrupt enable, status, counter, divider and compare read zero.
- R2: Counter ticks come every divider+1 clock cycles while run is set. A written divider value stays inactive until the next update event.
- R3: The counter steps from 0 up to the active top value. On the next tick it returns to 0, which is an update event and sets status bit 0.
- R4: Writing 1 to bit 0 of event generation clears the counter and the divider phase, loads the divider and the buffered top value, and sets status bit 0.
- R5: With control bit 1 set, the counter still wraps and keeps counting, but the wrap gives no update event and leaves status bit 0 unchanged.
- R6: With control bit 3 set, the run bit clears at the update event, so the counter stops at 0 after it wraps.
- R7: With control bit 7 clear, a top-value write applies at once. With bit 7 set, the write is held and only applies at the next update event.
- R8: The top-value register keeps only the counter width. It resets to all ones of that width, and writing 0xFFFFFFFF to a 16-bit instance reads back as 0x0000FFFF.
- R9: Status bit 1 is set on any tick that moves the counter onto the compare value, whether or not an update event happens.
- R10: A write to status clears each flag whose written bit is 0 and keeps each flag whose written bit is 1, so writing zero clears both flags.
- R11: The interrupt output is registered. It follows the OR of each flag that is set and enabled (interrupt-enable bit 0 for status bit 0, bit 1 for status bit 1) one cycle later.
- R12: Read data appears one cycle after the read request. A write to the counter register loads the counter directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check several invariants. The divider phase never passes the active divider value. An event-generation write leaves the counter at zero. A single-run update always drops the run bit. The update flag rises only from a software event or an unsuppressed wrap. The compare flag rises only when the counter has landed on the compare value. Reads of the top value never show bits above the counter width. Only the bench's scenarios can show the arithmetic of the count: the counter value after a known number of enabled cycles under various divider and top values, the deferred effect of a buffered top value, and how partial status writes interact with the interrupt enables.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/1ps
package cmp_timer_pkg;
  // Register byte offsets (software decodes these)
  localparam int OFS_CTL = 'h00;
  localparam int OFS_IEN = 'h0C;
  localparam int OFS_STS = 'h10;
  localparam int OFS_EGR = 'h14;
  localparam int OFS_CNT = 'h24;
  localparam int OFS_PSC = 'h28;
  localparam int OFS_ARR = 'h2C;
  localparam int OFS_CMP = 'h34;

  // Control bit positions
  localparam int CTL_RUN  = 0;
  localparam int CTL_NOUP = 1;
  localparam int CTL_ONCE = 3;
  localparam int CTL_BUF  = 7;

  // Flag positions shared by status and interrupt enable
  localparam int FLG_UPD = 0;
  localparam int FLG_CMP = 1;
  localparam int NFLG    = 2;

  typedef struct packed {
    logic ctl;
    logic ien;
    logic sts;
    logic egr;
    logic cnt;
    logic psc;
    logic arr;
    logic cmp;
  } wr_strobe_t;
endpackage

// File: rtl/cmp_timer_bus.sv
`timescale 1ns/1ps
module cmp_timer_bus
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rd_ctl,
  input  logic [DATA_W-1:0] rd_ien,
  input  logic [DATA_W-1:0] rd_sts,
  input  logic [DATA_W-1:0] rd_cnt,
  input  logic [DATA_W-1:0] rd_psc,
  input  logic [DATA_W-1:0] rd_arr,
  input  logic [DATA_W-1:0] rd_cmp,
  output wr_strobe_t        wstb,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wstb = '0;
    if (sel && wr) begin
      case (addr)
        ADDR_W'(OFS_CTL): wstb.ctl = 1'b1;
        ADDR_W'(OFS_IEN): wstb.ien = 1'b1;
        ADDR_W'(OFS_STS): wstb.sts = 1'b1;
        ADDR_W'(OFS_EGR): wstb.egr = 1'b1;
        ADDR_W'(OFS_CNT): wstb.cnt = 1'b1;
        ADDR_W'(OFS_PSC): wstb.psc = 1'b1;
        ADDR_W'(OFS_ARR): wstb.arr = 1'b1;
        ADDR_W'(OFS_CMP): wstb.cmp = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFS_CTL): rd_mux = rd_ctl;
      ADDR_W'(OFS_IEN): rd_mux = rd_ien;
      ADDR_W'(OFS_STS): rd_mux = rd_sts;
      ADDR_W'(OFS_CNT): rd_mux = rd_cnt;
      ADDR_W'(OFS_PSC): rd_mux = rd_psc;
      ADDR_W'(OFS_ARR): rd_mux = rd_arr;
      ADDR_W'(OFS_CMP): rd_mux = rd_cmp;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              rdata <= '0;
    else if (sel && !wr)  rdata <= rd_mux;
  end
endmodule

// File: rtl/cmp_timer_prescaler.sv
`timescale 1ns/1ps
module cmp_timer_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic             restart,
  input  logic             psc_wr,
  input  logic [PSC_W-1:0] wdata,
  output logic [PSC_W-1:0] psc_pre,
  output logic [PSC_W-1:0] psc_act,
  output logic [PSC_W-1:0] phase,
  output logic             tick
);
  assign tick = run && (phase == psc_act);

  always_ff @(posedge clk) begin
    if (rst)         psc_pre <= '0;
    else if (psc_wr) psc_pre <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       psc_act <= '0;
    else if (load) psc_act <= psc_pre;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) phase <= '0;
    else if (run)       phase <= tick ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/cmp_timer_counter.sv
`timescale 1ns/1ps
module cmp_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             load_top,
  input  logic             buf_en,
  input  logic             top_wr,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top_pre,
  output logic [CNT_W-1:0] cmp,
  output logic             wrap,
  output logic             hit
);
  localparam logic [CNT_W-1:0] TOP_RST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] top_act;
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;

  assign step    = tick && !restart && !cnt_wr;
  assign wrap    = step && (cnt == top_act);
  assign cnt_nxt = (cnt == top_act) ? '0 : cnt + 1'b1;
  assign hit     = step && (cnt_nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt_wr)    cnt <= wdata;
    else if (tick)      cnt <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)         top_pre <= TOP_RST;
    else if (top_wr) top_pre <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                   top_act <= TOP_RST;
    else if (top_wr && !buf_en) top_act <= wdata;
    else if (load_top)         top_act <= top_pre;
  end

  always_ff @(posedge clk) begin
    if (rst)         cmp <= '0;
    else if (cmp_wr) cmp <= wdata;
  end
endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int DATA_W = 32;

  wr_strobe_t       wstb;
  logic             ctl_run, ctl_noup, ctl_once, ctl_buf;
  logic [NFLG-1:0]  ien, sts, sts_set;
  logic             ug, wrap, hit, upd_ev, tick;
  logic [PSC_W-1:0] psc_pre, psc_act, phase;
  logic [CNT_W-1:0] cnt, top_pre, cmp;
  logic [DATA_W-1:0] rd_ctl;

  assign ug      = wstb.egr && bus_wdata[0];
  assign upd_ev  = ug || (wrap && !ctl_noup);
  assign sts_set = {hit, upd_ev};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_run <= 1'b0; ctl_noup <= 1'b0; ctl_once <= 1'b0; ctl_buf <= 1'b0;
    end else begin
      if (wstb.ctl) begin
        ctl_run  <= bus_wdata[CTL_RUN];
        ctl_noup <= bus_wdata[CTL_NOUP];
        ctl_once <= bus_wdata[CTL_ONCE];
        ctl_buf  <= bus_wdata[CTL_BUF];
      end
      if (upd_ev && ctl_once) ctl_run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ien <= '0;
    else if (wstb.ien)  ien <= bus_wdata[NFLG-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           sts <= '0;
    else if (wstb.sts) sts <= (sts & bus_wdata[NFLG-1:0]) | sts_set;
    else               sts <= sts | sts_set;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(sts & ien);
  end

  always_comb begin
    rd_ctl = '0;
    rd_ctl[CTL_RUN]  = ctl_run;
    rd_ctl[CTL_NOUP] = ctl_noup;
    rd_ctl[CTL_ONCE] = ctl_once;
    rd_ctl[CTL_BUF]  = ctl_buf;
  end

  cmp_timer_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(ctl_run), .load(upd_ev), .restart(ug),
    .psc_wr(wstb.psc), .wdata(bus_wdata[PSC_W-1:0]),
    .psc_pre(psc_pre), .psc_act(psc_act), .phase(phase), .tick(tick)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(ug), .load_top(upd_ev),
    .buf_en(ctl_buf), .top_wr(wstb.arr), .cnt_wr(wstb.cnt), .cmp_wr(wstb.cmp),
    .wdata(bus_wdata[CNT_W-1:0]), .cnt(cnt), .top_pre(top_pre), .cmp(cmp),
    .wrap(wrap), .hit(hit)
  );

  cmp_timer_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .rd_ctl(rd_ctl), .rd_ien(DATA_W'(ien)), .rd_sts(DATA_W'(sts)),
    .rd_cnt(DATA_W'(cnt)), .rd_psc(DATA_W'(psc_pre)),
    .rd_arr(DATA_W'(top_pre)), .rd_cmp(DATA_W'(cmp)),
    .wstb(wstb), .rdata(bus_rdata)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
`timescale 1ns/1ps
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              ctl_run,
  input logic              ctl_noup,
  input logic              ctl_once,
  input logic              ug,
  input logic              upd_ev,
  input logic [NFLG-1:0]   sts,
  input logic [NFLG-1:0]   ien,
  input logic [PSC_W-1:0]  psc_act,
  input logic [PSC_W-1:0]  phase,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp
);
  localparam logic [31:0] WMASK = 32'({CNT_W{1'b1}});

  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
    phase <= psc_act);

  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ug |=> (cnt == '0));

  assert_upd_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[FLG_UPD]) |-> $past(ug || !ctl_noup));

  assert_once_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_ev && ctl_once) |=> !ctl_run);

  assert_top_width_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_ARR)) |=> ((bus_rdata & ~WMASK) == '0));

  assert_cmp_land_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[FLG_CMP]) |-> (cnt == $past(cmp)));

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq);
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .ctl_run(ctl_run), .ctl_noup(ctl_noup),
  .ctl_once(ctl_once), .ug(ug), .upd_ev(upd_ev), .sts(sts), .ien(ien),
  .psc_act(psc_act), .phase(phase), .cnt(cnt), .cmp(cmp)
);

// File: tb/tb_cmp_timer.sv
`timescale 1ns/1ps
module tb_cmp_timer;
  localparam int TW = 16;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_CTL = 6'h00, A_IEN = 6'h0C, A_STS = 6'h10,
    A_EGR = 6'h14, A_CNT = 6'h24, A_PSC = 6'h28, A_ARR = 6'h2C, A_CMP = 6'h34;

  // Vector table: divider, top value, enabled cycles
  localparam int NV = 5;
  localparam int V_PSC [NV] = '{0, 3, 1, 0, 2};
  localparam int V_TOP [NV] = '{5, 100, 2, 1000, 0};
  localparam int V_CYC [NV] = '{8, 10, 13, 17, 7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] r;

  always #2.5 clk = ~clk;

  cmp_timer #(.CNT_W(TW), .PSC_W(16), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Run bit high for exactly n enabled clock edges (n >= 2)
  task automatic run(input logic [31:0] base, input int n);
    bw(A_CTL, base | 32'h1);
    idle(n - 2);
    bw(A_CTL, base & ~32'h1);
  endtask

  task automatic setup(input int psc, input int top);
    bw(A_CTL, 32'h0);
    bw(A_PSC, 32'(psc));
    bw(A_ARR, 32'(top));
    bw(A_EGR, 32'h1);
    bw(A_STS, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 / R8: reset state
    br(A_CTL, r); chk("R1 ctl reset", r, 32'h0);
    br(A_CNT, r); chk("R1 cnt reset", r, 32'h0);
    br(A_STS, r); chk("R1 sts reset", r, 32'h0);
    br(A_PSC, r); chk("R1 psc reset", r, 32'h0);
    br(A_ARR, r); chk("R8 top reset", r, 32'((1 << TW) - 1));
    chk("R11 irq reset", 32'(irq), 32'h0);

    // R1: control bit positions read back
    bw(A_CTL, 32'h8A); br(A_CTL, r); chk("R1 ctl bits", r, 32'h8A);

    // R8: width truncation
    bw(A_CTL, 32'h0);
    bw(A_ARR, 32'hFFFF_FFFF); br(A_ARR, r); chk("R8 width", r, 32'((1 << TW) - 1));

    // R2 / R3: table walk
    for (int i = 0; i < NV; i++) begin
      int ticks;
      setup(V_PSC[i], V_TOP[i]);
      run(32'h0, V_CYC[i]);
      ticks = V_CYC[i] / (V_PSC[i] + 1);
      br(A_CNT, r); chk("R2 R3 count", r, 32'(ticks % (V_TOP[i] + 1)));
      br(A_STS, r); chk("R3 wrap flag", r & 32'h1, (ticks > V_TOP[i]) ? 32'h1 : 32'h0);
    end

    // R2: divider write is inactive until update event
    setup(0, 1000);
    bw(A_PSC, 32'd3);
    run(32'h0, 10);
    br(A_CNT, r); chk("R2 divider held", r, 32'd10);
    bw(A_EGR, 32'h1);
    run(32'h0, 10);
    br(A_CNT, r); chk("R2 divider applied", r, 32'd2);

    // R4: software event clears counter, sets flag
    bw(A_STS, 32'h0);
    bw(A_EGR, 32'h1);
    br(A_CNT, r); chk("R4 cnt cleared", r, 32'h0);
    br(A_STS, r); chk("R4 flag", r & 32'h1, 32'h1);

    // R5: wrap without update flag
    setup(0, 5);
    run(32'h2, 8);
    br(A_CNT, r); chk("R5 keeps counting", r, 32'd2);
    br(A_STS, r); chk("R5 no flag", r & 32'h1, 32'h0);

    // R6: single run stops at wrap
    setup(0, 3);
    bw(A_CTL, 32'h9);
    idle(20);
    br(A_CTL, r); chk("R6 run cleared", r, 32'h8);
    br(A_CNT, r); chk("R6 stopped at 0", r, 32'h0);

    // R7: buffered top value
    bw(A_CTL, 32'h80);
    bw(A_ARR, 32'd9);
    bw(A_EGR, 32'h1);
    bw(A_ARR, 32'd2);
    run(32'h80, 5);
    br(A_CNT, r); chk("R7 old top active", r, 32'd5);
    bw(A_EGR, 32'h1);
    run(32'h80, 5);
    br(A_CNT, r); chk("R7 new top active", r, 32'd2);

    // R9: compare flag
    setup(0, 9);
    bw(A_CMP, 32'd4);
    run(32'h0, 6);
    br(A_STS, r); chk("R9 compare hit", r, 32'h2);
    bw(A_CMP, 32'd8);
    bw(A_EGR, 32'h1);
    bw(A_STS, 32'h0);
    run(32'h0, 6);
    br(A_STS, r); chk("R9 compare not reached", r, 32'h0);

    // R10: per-bit status clear
    bw(A_CMP, 32'd4);
    bw(A_EGR, 32'h1);
    bw(A_STS, 32'h0);
    run(32'h0, 6);
    bw(A_EGR, 32'h1);
    br(A_STS, r); chk("R10 both set", r, 32'h3);
    bw(A_STS, 32'h1);
    br(A_STS, r); chk("R10 keep bit0", r, 32'h1);
    bw(A_STS, 32'h0);
    br(A_STS, r); chk("R10 clear all", r, 32'h0);

    // R11: interrupt masking
    bw(A_IEN, 32'h2);
    run(32'h0, 6);
    idle(2); chk("R11 irq compare", 32'(irq), 32'h1);
    bw(A_IEN, 32'h1);
    idle(2); chk("R11 irq masked", 32'(irq), 32'h0);
    bw(A_IEN, 32'h2);
    idle(2); chk("R11 irq reenabled", 32'(irq), 32'h1);
    bw(A_STS, 32'h0);
    idle(2); chk("R11 irq after clear", 32'(irq), 32'h0);

    // R12: direct counter load and read latency
    bw(A_CNT, 32'd7);
    br(A_CNT, r); chk("R12 cnt load", r, 32'd7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule